// File: doc/BRIEF.md
# Run-Length Capture Compressor

This block sits between a sampling front end and the sample memory of a logic capture engine. It receives one capture word per strobe and hands the memory a stream of storage words with a write strobe. Before the capture is armed it writes every sample unchanged. After arming it folds runs of identical words into a single raw word followed by count words. The top bit of the active lane tells the two kinds of word apart.

The lane width is chosen at run time: a quarter, half or full `WORD_W`. Upstream packing decides what a word holds. Two narrow samples packed into one wider word are compared and counted as one unit. Double-rate 8-bit capture therefore runs in the 16-bit lane.

After arming, the flag position of incoming data is forced clear. A sample therefore never looks like a count word. A raw word is written when the next sample arrives, or on a flush. Because of this, each input cycle produces at most one storage word.

Top module: `rle_packer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are zero. After reset no run is pending.
- R2: While `arm` is low, each `in_valid` sample is written in the next cycle as `in_data` masked to the lane width. Its flag bit is kept, and any pending run state is discarded.
- R3: `mode` 0 selects a lane of `WORD_W/4` bits, 1 selects `WORD_W/2`, and 2 or 3 select `WORD_W`. For a lane of W bits, the flag is bit W-1 and the count field is bits W-2..0. Output bits at W and above are always zero.
- R4: While armed, a raw word has its flag bit clear. Two samples that differ only in the flag bit or above the lane are treated as equal.
- R5: While armed, a run of N≥2 equal samples produces its raw word and then count words whose counts sum to N-1. A count word is the flag bit set, with the count in the count field.
- R6: While armed, a run of one sample produces exactly one raw word and no count word.
- R7: When the pending count of a run reaches MAX = 2^(W-1)-1, a count word of MAX is written at once. Counting then restarts from zero, without a new raw word. A count word never holds zero.
- R8: When an armed sample differs from the current run, the run's pending word (its raw word, or else a non-zero count) is written in that cycle. The new sample's raw word is written later.
- R9: `flush` high with `in_valid` low writes the single pending word of the current run, if any, and ends the run. With nothing pending, or while unarmed, it writes nothing.
- R10: Every storage word appears on `out_valid`/`out_data` in the cycle after the clock edge that captured the causing input. `out_valid` never rises without `in_valid` or `flush` in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture word strobe |
| in_data | input | WORD_W | Capture word |
| arm | input | 1 | Compression enable (capture armed) |
| mode | input | 2 | Lane width select |
| flush | input | 1 | End of capture: write pending word |
| out_valid | output | 1 | Storage write strobe |
| out_data | output | WORD_W | Storage word (raw sample or run count) |

## Verification
The bench builds the block with `WORD_W` = 16. This gives lanes of 4, 8 and 16 bits, with maximum counts of 7, 127 and 32767. Run-length sweeps can therefore cross the saturation point in every mode, including the widest, within a short run. The quarter lane is small enough that every run length from 1 to 20 can be swept, and the pass-through path can be driven over many values in all four mode codes.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic [1:0] {
        LANE_QUARTER = 2'd0,
        LANE_HALF    = 2'd1,
        LANE_FULL    = 2'd2,
        LANE_FULL_B  = 2'd3
    } lane_mode_e;

    // Active lane width in bits for a mode code and a full word width.
    function automatic int lane_bits(input logic [1:0] m, input int word_w);
        lane_mode_e sel;
        sel = lane_mode_e'(m);
        case (sel)
            LANE_QUARTER: return word_w / 4;
            LANE_HALF:    return word_w / 2;
            default:      return word_w;
        endcase
    endfunction

endpackage

// File: rtl/rle_lane_cfg.sv
module rle_lane_cfg
    import rle_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] wmask,
    output logic [WORD_W-1:0] fmask,
    output logic [WORD_W-2:0] maxc
);
    int w;

    always_comb begin
        w = lane_bits(mode, WORD_W);
        for (int i = 0; i < WORD_W; i++) begin
            wmask[i] = (i < w);
            fmask[i] = (i == w - 1);
        end
        for (int i = 0; i < WORD_W - 1; i++) begin
            maxc[i] = (i < w - 1);
        end
    end
endmodule

// File: rtl/rle_cond.sv
module rle_cond #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] data,
    input  logic [WORD_W-1:0] wmask,
    input  logic [WORD_W-1:0] fmask,
    output logic [WORD_W-1:0] lane_raw,
    output logic [WORD_W-1:0] lane_cmp
);
    // Pass-through copy keeps the flag position; compare copy clears it.
    assign lane_raw = data & wmask;
    assign lane_cmp = data & wmask & ~fmask;
endmodule

// File: rtl/rle_word_fmt.sv
module rle_word_fmt #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-2:0] count,
    input  logic [WORD_W-1:0] fmask,
    output logic [WORD_W-1:0] cword
);
    assign cword = fmask | {1'b0, count};
endmodule

// File: rtl/rle_packer.sv
module rle_packer
    import rle_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              arm,
    input  logic [1:0]        mode,
    input  logic              flush,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    localparam int CNT_W = WORD_W - 1;

    typedef struct packed {
        logic              run_vld;   // a run is open
        logic              raw_done;  // its raw word is already stored
        logic [WORD_W-1:0] run_val;   // flag-cleared lane value of the run
        logic [CNT_W-1:0]  cnt;       // repeats not yet stored
        logic              wr;
        logic [WORD_W-1:0] word;
    } pk_state_t;

    pk_state_t st_d, st_q;

    logic [WORD_W-1:0] wmask, fmask;
    logic [CNT_W-1:0]  maxc;
    logic [WORD_W-1:0] lane_raw, lane_cmp;
    logic [WORD_W-1:0] cw_pend, cw_full;
    logic [CNT_W-1:0]  cnt_inc;

    rle_lane_cfg #(.WORD_W(WORD_W)) cfg_i (
        .mode  (mode),
        .wmask (wmask),
        .fmask (fmask),
        .maxc  (maxc)
    );

    rle_cond #(.WORD_W(WORD_W)) cond_i (
        .data     (in_data),
        .wmask    (wmask),
        .fmask    (fmask),
        .lane_raw (lane_raw),
        .lane_cmp (lane_cmp)
    );

    rle_word_fmt #(.WORD_W(WORD_W)) fmt_pend_i (
        .count (st_q.cnt),
        .fmask (fmask),
        .cword (cw_pend)
    );

    rle_word_fmt #(.WORD_W(WORD_W)) fmt_full_i (
        .count (maxc),
        .fmask (fmask),
        .cword (cw_full)
    );

    assign cnt_inc = st_q.cnt + CNT_W'(1);

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;

        if (!arm) begin
            // pass-through: every sample stored as it is
            st_d.run_vld  = 1'b0;
            st_d.raw_done = 1'b0;
            st_d.cnt      = '0;
            if (in_valid) begin
                st_d.wr   = 1'b1;
                st_d.word = lane_raw;
            end
        end else if (in_valid) begin
            if (!st_q.run_vld) begin
                st_d.run_vld  = 1'b1;
                st_d.raw_done = 1'b0;
                st_d.run_val  = lane_cmp;
                st_d.cnt      = '0;
            end else if (lane_cmp == st_q.run_val) begin
                if (!st_q.raw_done) begin
                    st_d.wr       = 1'b1;
                    st_d.word     = st_q.run_val;
                    st_d.raw_done = 1'b1;
                    st_d.cnt      = CNT_W'(1);
                end else if (cnt_inc == maxc) begin
                    st_d.wr   = 1'b1;
                    st_d.word = cw_full;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end else begin
                if (!st_q.raw_done) begin
                    st_d.wr   = 1'b1;
                    st_d.word = st_q.run_val;
                end else if (st_q.cnt != '0) begin
                    st_d.wr   = 1'b1;
                    st_d.word = cw_pend;
                end
                st_d.run_val  = lane_cmp;
                st_d.raw_done = 1'b0;
                st_d.cnt      = '0;
            end
        end else if (flush) begin
            if (st_q.run_vld) begin
                if (!st_q.raw_done) begin
                    st_d.wr   = 1'b1;
                    st_d.word = st_q.run_val;
                end else if (st_q.cnt != '0) begin
                    st_d.wr   = 1'b1;
                    st_d.word = cw_pend;
                end
            end
            st_d.run_vld  = 1'b0;
            st_d.raw_done = 1'b0;
            st_d.cnt      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.wr;
    assign out_data  = st_q.word;

endmodule

// File: rtl/rle_packer_chk.sv
module rle_packer_chk
    import rle_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_data,
    input logic              arm,
    input logic [1:0]        mode,
    input logic              flush,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data
);
    function automatic logic [WORD_W-1:0] lmask(input logic [1:0] m);
        logic [WORD_W-1:0] r;
        int w;
        w = lane_bits(m, WORD_W);
        for (int i = 0; i < WORD_W; i++) r[i] = (i < w);
        return r;
    endfunction

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_data == '0));

    // R10
    write_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid || flush));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !arm) |->
            (out_valid && out_data == ($past(in_data) & lmask($past(mode)))));

    // R3
    lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~lmask($past(mode))) == '0));

    // R7
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(arm) &&
         ((out_data & (lmask($past(mode)) ^ (lmask($past(mode)) >> 1))) != '0))
            |-> ((out_data & (lmask($past(mode)) >> 1)) != '0));

    // R9
    idle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush && !in_valid && !arm) |-> !out_valid);

endmodule

bind rle_packer rle_packer_chk #(.WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .arm       (arm),
    .mode      (mode),
    .flush     (flush),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/rle_packer_tb_top.sv
`timescale 1ns/1ps
module rle_packer_tb_top;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [WW-1:0] in_data = '0;
    logic          arm = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          flush = 1'b0;
    logic          out_valid;
    logic [WW-1:0] out_data;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R2";
    logic [WW-1:0] exp_q[$];

    always #4 clk = ~clk;

    rle_packer #(.WORD_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .arm(arm), .mode(mode), .flush(flush),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // lane width per R3
    function automatic int wid(input int m);
        if (m == 0) return WW / 4;
        if (m == 1) return WW / 2;
        return WW;
    endfunction

    always @(negedge clk) begin
        if (mon_en && rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, int'(out_data), -1);
            end else begin
                logic [WW-1:0] e;
                e = exp_q.pop_front();
                check(out_data == e, cur_req, int'(out_data), int'(e));
            end
        end
    end

    task automatic drive(input logic v, input logic [WW-1:0] dd, input logic f);
        @(negedge clk);
        in_valid = v;
        in_data  = dd;
        flush    = f;
    endtask

    task automatic drain(input string req);
        repeat (3) drive(1'b0, '0, 1'b0);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // one armed run: expected words from R5/R6/R7, samples carry noise (R4)
    task automatic play_run(input int v, input int len, input int m);
        int w, fb, mx, rep, noise;
        w     = wid(m);
        fb    = 1 << (w - 1);
        mx    = fb - 1;
        noise = 'h5A5A & ~((1 << w) - 1) & 'hFFFF;
        exp_q.push_back(WW'(v));
        rep = len - 1;
        for (int k = 0; k < rep / mx; k++) exp_q.push_back(WW'(fb | mx));
        if (rep % mx != 0) exp_q.push_back(WW'(fb | (rep % mx)));
        for (int k = 0; k < len; k++)
            drive(1'b1, WW'(v | noise | ((k % 2 == 1) ? fb : 0)), 1'b0);
    endtask

    task automatic run_set(input int m, input int n, input int lens[8], input bit sweep);
        int mx;
        mx = (1 << (wid(m) - 1)) - 1;
        @(negedge clk);
        mode = 2'(m);
        arm  = 1'b1;
        for (int i = 0; i < n; i++)
            play_run((i * 5 + 3) & mx, sweep ? (i + 1) : lens[i], m);
        drive(1'b0, '0, 1'b1);
        drain(cur_req);
    endtask

    initial begin
        int lens_a[8];
        int lens_b[8];
        lens_a = '{1, 2, 126, 127, 128, 129, 255, 300};
        lens_b = '{1, 2, 32768, 5, 3, 1, 1, 1};

        // R1: reset
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        mon_en = 1'b1;

        // R2 / R3: pass-through in every mode code
        for (int m = 0; m < 4; m++) begin
            cur_req = "R2 R3";
            @(negedge clk);
            mode = 2'(m);
            for (int d = 0; d < 80; d++) begin
                int raw;
                raw = (d * 1031 + 17 * m) ^ 'h9C3F;
                exp_q.push_back(WW'(raw & ((1 << wid(m)) - 1)));
                drive(1'b1, WW'(raw), 1'b0);
            end
            drain("R2 R3");
        end

        // R9: flush while unarmed writes nothing
        cur_req = "R9";
        drive(1'b0, '0, 1'b1);
        drive(1'b0, '0, 1'b0);
        check(out_valid == 1'b0, "R9", int'(out_valid), 0);

        // R5 R6 R7 R8: quarter lane, run lengths 1..20
        cur_req = "R5 R6 R7 R8 quarter";
        run_set(0, 20, lens_a, 1'b1);
        // half lane around MAX=127
        cur_req = "R5 R7 R8 half";
        run_set(1, 8, lens_a, 1'b0);
        // full lane, one exact saturation
        cur_req = "R5 R7 R8 full";
        run_set(2, 8, lens_b, 1'b0);

        // R4: samples differing only in flag bit form one run (quarter lane)
        cur_req = "R4";
        @(negedge clk);
        mode = 2'd0;
        exp_q.push_back(WW'('h3));
        exp_q.push_back(WW'('hB));
        drive(1'b1, WW'('hB), 1'b0);
        drive(1'b1, WW'('h3), 1'b0);
        drive(1'b1, WW'('hB), 1'b0);
        drive(1'b1, WW'('h3), 1'b0);
        drive(1'b0, '0, 1'b1);
        drain("R4");

        // R9: flush with nothing pending
        cur_req = "R9";
        drive(1'b0, '0, 1'b1);
        drive(1'b0, '0, 1'b0);
        check(out_valid == 1'b0, "R9", int'(out_valid), 0);

        // R10 / R8: exact cycle of each word
        mon_en = 1'b0;
        drive(1'b1, WW'('h5), 1'b0);
        drive(1'b1, WW'('h5), 1'b0);
        check(out_valid == 1'b0, "R10 first sample held", int'(out_valid), 0);
        drive(1'b1, WW'('h6), 1'b0);
        check(out_valid && out_data == WW'('h5), "R10 raw after repeat", int'(out_data), 'h5);
        drive(1'b0, '0, 1'b0);
        check(out_valid && out_data == WW'('h9), "R8 count before new raw", int'(out_data), 'h9);
        drive(1'b0, '0, 1'b1);
        check(out_valid == 1'b0, "R10 idle cycle", int'(out_valid), 0);
        drive(1'b0, '0, 1'b0);
        check(out_valid && out_data == WW'('h6), "R9 flush raw", int'(out_data), 'h6);
        drive(1'b0, '0, 1'b0);
        check(out_valid == 1'b0, "R9 single word", int'(out_valid), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule